// File: doc/BRIEF.md
# Shared Threshold Alert Generator

This block watches the results of a multi-channel converter and raises one active-low alert pin whenever a finished conversion lands outside a window. The window is given by a high limit and a low limit, and every channel uses the same two limits. Results are compared only in the cycle that carries the conversion-done strobe. Results present at any other time are never looked at.

For each channel the block keeps two sticky flags. One says the high limit was exceeded and the other says the result fell under the low limit. A reader can therefore tell which channel tripped and in which direction. The pin and the flags stay set until the host pulls chip select low. That falling edge clears them. An enable input switches the whole function off. A parameter chooses whether results and limits are read as two's-complement or unsigned numbers.

Top module: `thresh_alert`

## Requirements
- R1: In a cycle with `conv_done` high and `alert_en` high, a channel whose result is strictly greater than `lim_hi` sets its bit `ch` of `flag_hi` at that clock edge. Channel `ch` occupies `results[ch*DW +: DW]`.
- R2: In a cycle with `conv_done` high and `alert_en` high, a channel whose result is strictly less than `lim_lo` sets its bit `ch` of `flag_lo` at that clock edge.
- R3: A result equal to `lim_hi` or equal to `lim_lo` sets no flag.
- R4: `alert_n` is low exactly when at least one bit of `flag_hi` or `flag_lo` is set. It changes at the same clock edge as the flags. The pin can only fall at an edge where `conv_done` was high.
- R5: Flags are sticky. A later conversion ORs its new flags into the stored ones. Results presented while `conv_done` is low change nothing.
- R6: A chip-select falling edge clears all flags and releases `alert_n` to high. The edge is `cs_n` seen high at one clock and low at the next.
- R7: If a violating conversion arrives in the same cycle as a chip-select falling edge, the old flags are dropped. The new violation's flags are stored and `alert_n` stays low.
- R8: While `alert_en` is low, `alert_n` is high, all flags are zero and violations are ignored.
- R9: With `SIGNED_DATA=1`, results and limits are compared as two's-complement numbers. With `SIGNED_DATA=0`, they are compared as unsigned numbers.
- R10: After reset `alert_n` is high and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Strobe marking that `results` holds a finished conversion |
| results | input | NCH*DW | Per-channel results, channel ch at bits ch*DW +: DW |
| lim_hi | input | DW | Shared high limit |
| lim_lo | input | DW | Shared low limit |
| alert_en | input | 1 | Enables comparison and alerting |
| cs_n | input | 1 | Chip select, active low; its falling edge clears the alert |
| alert_n | output | 1 | Shared alert, low while any flag is set |
| flag_hi | output | NCH | Per-channel sticky above-high flags |
| flag_lo | output | NCH | Per-channel sticky below-low flags |

## Verification
The hardest case to produce is R7. It needs a violating conversion strobe in exactly the cycle where `cs_n` goes from high to low, and stored flags from an earlier conversion must already be present. The stimulus first plants flags on other channels with one conversion. It then drives the `cs_n` fall and a new violating strobe on the same negative edge, so both are seen at the same rising edge. A second instance built with unsigned comparison receives the same stimulus. Data near the sign boundary then makes the two instances disagree in the way R9 predicts.

// File: rtl/thresh_alert.sv
module thresh_alert #(
  parameter int NCH = 4,
  parameter int DW = 16,
  parameter bit SIGNED_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [NCH*DW-1:0] results,
  input  logic [DW-1:0]     lim_hi,
  input  logic [DW-1:0]     lim_lo,
  input  logic              alert_en,
  input  logic              cs_n,
  output logic              alert_n,
  output logic [NCH-1:0]    flag_hi,
  output logic [NCH-1:0]    flag_lo
);

  logic           cs_q;
  logic           cs_fall;
  logic [NCH-1:0] over, under;
  logic [NCH-1:0] nxt_hi, nxt_lo;

  assign cs_fall = cs_q & ~cs_n;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [DW-1:0] smp;
    assign smp = results[g*DW +: DW];
    if (SIGNED_DATA) begin : g_s
      assign over[g]  = conv_done && ($signed(smp) > $signed(lim_hi));
      assign under[g] = conv_done && ($signed(smp) < $signed(lim_lo));
    end else begin : g_u
      assign over[g]  = conv_done && (smp > lim_hi);
      assign under[g] = conv_done && (smp < lim_lo);
    end
  end

  always_comb begin
    if (!alert_en) begin
      nxt_hi = '0;
      nxt_lo = '0;
    end else if (cs_fall) begin
      nxt_hi = over;
      nxt_lo = under;
    end else begin
      nxt_hi = flag_hi | over;
      nxt_lo = flag_lo | under;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      flag_hi <= '0;
      flag_lo <= '0;
      alert_n <= 1'b1;
    end else begin
      cs_q    <= cs_n;
      flag_hi <= nxt_hi;
      flag_lo <= nxt_lo;
      alert_n <= ~(|{nxt_hi, nxt_lo});
    end
  end

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_en && !conv_done && !cs_fall) |=> ($stable(flag_hi) && $stable(flag_lo)));

  assert_fall_needs_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> $past(conv_done));

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_en |=> (alert_n && flag_hi == '0 && flag_lo == '0));

  assert_release_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_n) |-> $past(!alert_en || cs_fall));

endmodule

// File: tb/tb_thresh_alert.sv
module tb_thresh_alert;
  localparam int NCH = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done = 1'b0;
  logic [NCH*DW-1:0] results = '0;
  logic [DW-1:0] lim_hi = 16'd1000;
  logic [DW-1:0] lim_lo = 16'hFC18; // -1000
  logic alert_en = 1'b1;
  logic cs_n = 1'b1;
  logic a_s, a_u;
  logic [NCH-1:0] fh_s, fl_s, fh_u, fl_u;

  always #2 clk = ~clk;

  thresh_alert #(.NCH(NCH), .DW(DW), .SIGNED_DATA(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .results(results),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .alert_en(alert_en), .cs_n(cs_n),
    .alert_n(a_s), .flag_hi(fh_s), .flag_lo(fl_s));

  thresh_alert #(.NCH(NCH), .DW(DW), .SIGNED_DATA(1'b0)) dut_u (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .results(results),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .alert_en(alert_en), .cs_n(cs_n),
    .alert_n(a_u), .flag_hi(fh_u), .flag_lo(fl_u));

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string phase = "R10 reset";

  bit m_cs [2];
  int m_hi [2][NCH];
  int m_lo [2][NCH];

  function automatic bit above(logic [DW-1:0] a, logic [DW-1:0] b, bit sg);
    if (sg) return $signed(a) > $signed(b);
    return a > b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_cs[k] = 1'b1;
        for (int c = 0; c < NCH; c++) begin m_hi[k][c] = 0; m_lo[k][c] = 0; end
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit fall;
        fall = m_cs[k] && !cs_n;
        for (int c = 0; c < NCH; c++) begin
          bit oh, ol;
          logic [DW-1:0] v;
          v = results[c*DW +: DW];
          oh = conv_done && above(v, lim_hi, k == 0);
          ol = conv_done && above(lim_lo, v, k == 0);
          if (!alert_en) begin m_hi[k][c] = 0; m_lo[k][c] = 0; end
          else if (fall) begin m_hi[k][c] = oh; m_lo[k][c] = ol; end
          else begin m_hi[k][c] = m_hi[k][c] | oh; m_lo[k][c] = m_lo[k][c] | ol; end
        end
        m_cs[k] = cs_n;
      end
    end
  end

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      logic [NCH-1:0] eh, el, gh, gl;
      logic ea, ga;
      for (int c = 0; c < NCH; c++) begin eh[c] = m_hi[k][c][0]; el[c] = m_lo[k][c][0]; end
      ea = ~(|{eh, el});
      gh = (k == 0) ? fh_s : fh_u;
      gl = (k == 0) ? fl_s : fl_u;
      ga = (k == 0) ? a_s : a_u;
      compared++;
      if (gh !== eh || gl !== el || ga !== ea) begin
        mismatched++;
        $display("FAIL %s inst%0d: got alert_n=%b hi=%b lo=%b expected alert_n=%b hi=%b lo=%b",
                 phase, k, ga, gh, gl, ea, eh, el);
      end
    end
  end

  task automatic conv(input logic [DW-1:0] r0, r1, r2, r3);
    @(negedge clk);
    results = {r3, r2, r1, r0};
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    results = {4{16'h7FFF}};
  endtask

  task automatic cs_pulse();
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    phase = "R1 above high";
    conv(16'd1001, 16'd5, 16'd0, 16'd0);
    repeat (2) @(negedge clk);
    phase = "R5 sticky and ignored results";
    results = {4{16'h7FFF}};
    repeat (3) @(negedge clk);
    phase = "R2 below low";
    conv(16'd0, 16'd0, 16'hFC17, 16'd0);
    repeat (2) @(negedge clk);
    phase = "R6 cs fall clears";
    cs_pulse();
    repeat (2) @(negedge clk);
    phase = "R3 equal to limits";
    conv(16'd1000, 16'hFC18, 16'd1000, 16'hFC18);
    repeat (2) @(negedge clk);
    phase = "R4 pin follows flags";
    conv(16'd0, 16'd0, 16'd0, 16'd2000);
    @(negedge clk);
    phase = "R7 coincident violation";
    conv(16'd0, 16'd0, 16'd0, 16'd0);
    cs_n = 1'b1;
    @(negedge clk);
    results = {16'd0, 16'd0, 16'hF000, 16'd0};
    conv_done = 1'b1;
    cs_n = 1'b0;
    @(negedge clk);
    conv_done = 1'b0;
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_pulse();
    phase = "R9 signedness";
    conv(16'hFFFF, 16'h8000, 16'h7FFF, 16'd1);
    repeat (2) @(negedge clk);
    cs_pulse();
    phase = "R8 disabled";
    @(negedge clk); alert_en = 1'b0;
    conv(16'd3000, 16'hF000, 16'd3000, 16'hF000);
    repeat (2) @(negedge clk);
    alert_en = 1'b1;
    phase = "R8 disabled clears stored";
    conv(16'd3000, 16'd0, 16'd0, 16'd0);
    @(negedge clk); alert_en = 1'b0;
    repeat (2) @(negedge clk); alert_en = 1'b1;
    phase = "R10 reset again";
    conv(16'd3000, 16'd0, 16'd0, 16'd0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog in %s: got hang expected completion", phase);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule